// File: doc/BRIEF.md
# Dual-Issue Variable-Length Instruction Marshaller

This block is the front end of a two-wide pipeline in which every instruction is one, two or three 16-bit syllables long. It holds a small prefetch queue of syllables that a memory port refills a whole chunk at a time. Each cycle it looks at the head of the queue and decides whether the head instruction can go to the full pipeline (lane A), and whether the instruction after it can go to the reduced pipeline (lane B) in the same cycle.

Lane B is limited by the data paths that exist. Its first syllable can only come from queue positions 1 to 3, and its second syllable only from positions 2 or 3. It never takes three-syllable instructions, and it never takes memory-reference instructions. Issue stays strictly in program order, so an extension syllable always travels with the instruction it belongs to. After issue the queue shifts down by the number of syllables consumed, and a new chunk is accepted when enough room is left after that shift.

Top module: `dual_issue_marshal`

## Requirements
- R1: While reset is asserted and after it is released, the queue is empty. Neither lane issues, and `fill_ready` is 1.
- R2: The top two bits of an instruction's first syllable give its length: 00 or 01 means one syllable, 10 means two, 11 means three. `a_len`/`b_len` report this value in a cycle where the lane issues and are 0 otherwise.
- R3: When `a_ready` is 1 and the queue holds at least as many valid syllables as the head instruction needs, `a_issue` is 1 in that same cycle. Any instruction length from 1 to 3 may issue this way.
- R4: When the queue holds fewer valid syllables than the head instruction needs, neither lane issues.
- R5: When `a_ready` is 0, neither lane issues, whatever `b_ready` is.
- R6: `b_issue` is 1 only when all of these hold in the same cycle: `a_issue` is 1, `b_ready` is 1, and the instruction right after the head is one or two syllables long and fully present in the queue.
- R7: When a three-syllable head is followed by a one-syllable instruction, both issue together. When it is followed by a two-syllable instruction, only the head issues.
- R8: A three-syllable instruction never issues on lane B.
- R9: An instruction whose first syllable has bit 13 set is a memory reference and never issues on lane B.
- R10: Syllable slot k of `a_syl`/`b_syl` sits at bits [16k+15:16k]. It carries the k-th syllable of the issued instruction, and slots beyond the length are 0. After issue, the queue shifts by the number of syllables consumed, so the following instructions come out in program order.
- R11: `fill_ready` is 1 exactly when at most two syllables remain after this cycle's shift. A chunk accepted with `fill_valid` is appended behind the remaining syllables, with its syllable 0 taken from the lowest 16 bits.
- R12: When `a_ready` is 1 and `b_ready` is 0, lane A still issues alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | A chunk of syllables is offered |
| fill_data | input | 64 | Four syllables, syllable 0 in the low bits |
| fill_ready | output | 1 | Chunk accepted this cycle when `fill_valid` is 1 |
| a_ready | input | 1 | Full pipeline can take an instruction |
| a_issue | output | 1 | Head instruction goes to the full pipeline this cycle |
| a_len | output | 2 | Length in syllables of the lane A instruction |
| a_syl | output | 48 | Lane A syllables, slot 0 in the low bits |
| b_ready | input | 1 | Reduced pipeline can take an instruction |
| b_issue | output | 1 | Second instruction goes to the reduced pipeline this cycle |
| b_len | output | 2 | Length in syllables of the lane B instruction |
| b_syl | output | 32 | Lane B syllables, slot 0 in the low bits |

## Verification
Dual issue and chunk refill can happen in the same cycle. When both occur, the refill must land behind a remainder that has just shrunk by up to four syllables, and `fill_ready` must reflect that post-issue remainder rather than the old count. The bench provokes this by streaming every ordered pair of the six instruction shapes (three lengths, memory or not) while the memory port offers data on most cycles. It judges each cycle against a queue model, built from the requirements, that applies the shift and the append in that same cycle, so a wrongly placed chunk appears as wrong syllables on a later issue.

// File: rtl/dim_pkg.sv
package dim_pkg;
   typedef logic [1:0] dim_len_t;

   localparam dim_len_t LEN1 = 2'd1;
   localparam dim_len_t LEN2 = 2'd2;
   localparam dim_len_t LEN3 = 2'd3;

   // widest single-cycle consumption: 3+1 or 2+2 syllables
   localparam int MAX_USE = 4;

   function automatic dim_len_t dim_len_of(input logic [1:0] top);
      return (top == 2'b11) ? LEN3 : ((top == 2'b10) ? LEN2 : LEN1);
   endfunction
endpackage

// File: rtl/dim_len_dec.sv
module dim_len_dec
   import dim_pkg::*;
(
   input  logic [1:0] top_bits,
   output dim_len_t   len
);
   assign len = dim_len_of(top_bits);
endmodule

// File: rtl/dim_issue_sel.sv
module dim_issue_sel
   import dim_pkg::*;
#(
   parameter int CNT_W      = 3,
   parameter bit LOCK_MEM_B = 1'b1
) (
   input  logic [CNT_W-1:0]  occ,
   input  dim_len_t [3:0]    len_q,
   input  logic [3:1]        mem_q,
   input  logic              a_ready,
   input  logic              b_ready,
   output logic              a_go,
   output logic              b_go,
   output dim_len_t          a_len_o,
   output dim_len_t          b_len_o,
   output logic [CNT_W-1:0]  used
);
   dim_len_t la, lb;
   logic     fol_mem, b_block, b_route, b_whole;

   assign la = len_q[0];

   // follower sits at position la (1..3)
   always_comb begin
      unique case (la)
         LEN1:    begin lb = len_q[1]; fol_mem = mem_q[1]; end
         LEN2:    begin lb = len_q[2]; fol_mem = mem_q[2]; end
         default: begin lb = len_q[3]; fol_mem = mem_q[3]; end
      endcase
   end

   generate
      if (LOCK_MEM_B) begin : g_lock
         assign b_block = fol_mem;
      end else begin : g_open
         assign b_block = 1'b0;
      end
   endgenerate

   // second syllable of lane B reachable only from positions 2 or 3
   assign b_route = (lb == LEN1) || ((lb == LEN2) && (la != LEN3));
   assign b_whole = occ >= (CNT_W'(la) + CNT_W'(lb));

   assign a_go = a_ready && (occ >= CNT_W'(la));
   assign b_go = a_go && b_ready && b_route && b_whole && !b_block;

   assign a_len_o = a_go ? la : '0;
   assign b_len_o = b_go ? lb : '0;
   assign used    = (a_go ? CNT_W'(la) : '0) + (b_go ? CNT_W'(lb) : '0);
endmodule

// File: rtl/dim_prefetch_buf.sv
module dim_prefetch_buf #(
   parameter int SYL_W  = 16,
   parameter int BUF_N  = 6,
   parameter int FILL_N = 4,
   parameter int CNT_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [CNT_W-1:0]         used,
   input  logic                     fill_valid,
   input  logic [FILL_N*SYL_W-1:0]  fill_data,
   output logic                     fill_ready,
   output logic [CNT_W-1:0]         occ,
   output logic [3:0][SYL_W-1:0]    win
);
   localparam int QW = BUF_N * SYL_W;

   logic [QW-1:0]    ent_q, ent_d, kept, ins;
   logic [CNT_W-1:0] occ_q, rem;
   logic             take;

   assign rem        = occ_q - used;
   assign fill_ready = rem <= CNT_W'(BUF_N - FILL_N);
   assign take       = fill_valid && fill_ready;

   // entries at or above occ_q are kept at zero, so shift and OR suffice
   assign kept  = ent_q >> (int'(used) * SYL_W);
   assign ins   = QW'(fill_data) << (int'(rem) * SYL_W);
   assign ent_d = kept | (take ? ins : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_q <= '0;
         occ_q <= '0;
      end else begin
         ent_q <= ent_d;
         occ_q <= rem + (take ? CNT_W'(FILL_N) : '0);
      end
   end

   assign occ = occ_q;
   assign win = ent_q[4*SYL_W-1:0];
endmodule

// File: rtl/dual_issue_marshal.sv
module dual_issue_marshal
   import dim_pkg::*;
#(
   parameter int SYL_W      = 16,
   parameter int BUF_N      = 6,
   parameter int FILL_N     = 4,
   parameter int MEM_BIT    = 13,
   parameter bit LOCK_MEM_B = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fill_valid,
   input  logic [FILL_N*SYL_W-1:0]  fill_data,
   output logic                     fill_ready,
   input  logic                     a_ready,
   output logic                     a_issue,
   output logic [1:0]               a_len,
   output logic [3*SYL_W-1:0]       a_syl,
   input  logic                     b_ready,
   output logic                     b_issue,
   output logic [1:0]               b_len,
   output logic [2*SYL_W-1:0]       b_syl
);
   localparam int CNT_W = $clog2(BUF_N + 1);

   generate
      if (BUF_N < MAX_USE) begin : g_bad_depth
         $error("BUF_N must cover the four-syllable issue window");
      end
      if (FILL_N < 1 || FILL_N > BUF_N) begin : g_bad_fill
         $error("FILL_N must lie between 1 and BUF_N");
      end
      if (MEM_BIT < 0 || MEM_BIT > SYL_W - 3) begin : g_bad_mem
         $error("MEM_BIT must sit below the two length bits");
      end
   endgenerate

   logic [3:0][SYL_W-1:0] win;
   logic [CNT_W-1:0]      occ, used;
   dim_len_t [3:0]        lens;
   logic [3:1]            mems;
   dim_len_t              la, lb;
   logic                  a_go, b_go;

   dim_prefetch_buf #(
      .SYL_W (SYL_W),
      .BUF_N (BUF_N),
      .FILL_N(FILL_N),
      .CNT_W (CNT_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .used      (used),
      .fill_valid(fill_valid),
      .fill_data (fill_data),
      .fill_ready(fill_ready),
      .occ       (occ),
      .win       (win)
   );

   for (genvar p = 0; p < 4; p++) begin : g_dec
      dim_len_dec u_dec (
         .top_bits(win[p][SYL_W-1 -: 2]),
         .len     (lens[p])
      );
      if (p > 0) begin : g_mem
         assign mems[p] = win[p][MEM_BIT];
      end
   end

   dim_issue_sel #(
      .CNT_W     (CNT_W),
      .LOCK_MEM_B(LOCK_MEM_B)
   ) u_sel (
      .occ    (occ),
      .len_q  (lens),
      .mem_q  (mems),
      .a_ready(a_ready),
      .b_ready(b_ready),
      .a_go   (a_go),
      .b_go   (b_go),
      .a_len_o(la),
      .b_len_o(lb),
      .used   (used)
   );

   // lane A: head of the queue, slots beyond the length read as zero
   for (genvar k = 0; k < 3; k++) begin : g_aslot
      assign a_syl[k*SYL_W +: SYL_W] = (2'(k) < la) ? win[k] : '0;
   end

   // lane B: first syllable from 1..3, second only from 2..3
   always_comb begin
      b_syl = '0;
      if (b_go) begin
         unique case (lens[0])
            LEN1: begin
               b_syl[SYL_W-1:0] = win[1];
               if (lb == LEN2) b_syl[2*SYL_W-1:SYL_W] = win[2];
            end
            LEN2: begin
               b_syl[SYL_W-1:0] = win[2];
               if (lb == LEN2) b_syl[2*SYL_W-1:SYL_W] = win[3];
            end
            default: b_syl[SYL_W-1:0] = win[3];
         endcase
      end
   end

   assign a_issue = a_go;
   assign b_issue = b_go;
   assign a_len   = la;
   assign b_len   = lb;
endmodule

// File: rtl/dim_marshal_chk.sv
module dim_marshal_chk #(
   parameter int CNT_W      = 3,
   parameter bit LOCK_MEM_B = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_ready,
   input logic             b_ready,
   input logic             a_issue,
   input logic             b_issue,
   input logic [1:0]       a_len,
   input logic [1:0]       b_len,
   input logic [1:0]       a_top,
   input logic             b_mem,
   input logic [CNT_W-1:0] occ
);
   assert_len_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      a_issue |-> a_len == ((a_top == 2'b11) ? 2'd3 : ((a_top == 2'b10) ? 2'd2 : 2'd1)));

   assert_head_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
      a_issue |-> CNT_W'(a_len) <= occ);

   assert_a_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !a_ready |-> (!a_issue && !b_issue));

   assert_b_follows_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      b_issue |-> (a_issue && b_ready));

   assert_no_three_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_issue && a_len == 2'd3) |-> b_len == 2'd1);

   assert_b_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
      b_issue |-> (b_len == 2'd1 || b_len == 2'd2));

   assert_memref_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (b_issue && LOCK_MEM_B) |-> !b_mem);
endmodule

bind dual_issue_marshal dim_marshal_chk #(
   .CNT_W     (CNT_W),
   .LOCK_MEM_B(LOCK_MEM_B)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .a_ready(a_ready),
   .b_ready(b_ready),
   .a_issue(a_issue),
   .b_issue(b_issue),
   .a_len  (a_len),
   .b_len  (b_len),
   .a_top  (a_syl[SYL_W-1 -: 2]),
   .b_mem  (b_syl[MEM_BIT]),
   .occ    (occ)
);

// File: tb/tb_dual_issue_marshal.sv
module tb_dual_issue_marshal;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_valid = 1'b0;
   logic [63:0] fill_data = '0;
   logic        fill_ready;
   logic        a_ready = 1'b0, b_ready = 1'b0;
   logic        a_issue, b_issue;
   logic [1:0]  a_len, b_len;
   logic [47:0] a_syl;
   logic [31:0] b_syl;

   always #10 clk = ~clk;

   dual_issue_marshal dut (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
      .a_ready(a_ready), .a_issue(a_issue), .a_len(a_len), .a_syl(a_syl),
      .b_ready(b_ready), .b_issue(b_issue), .b_len(b_len), .b_syl(b_syl)
   );

   int checks = 0, fails = 0;
   logic [15:0] strm [0:255];
   int nbody;
   logic [15:0] mq [0:5];
   int mcnt, sp, done_n;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int lenof(input logic [15:0] s);
      return s[15] ? (s[14] ? 3 : 2) : 1;
   endfunction

   // R2 encodings and R9 memory bit (13) used to build instructions
   task automatic build_stream();
      int idx = 0;
      int ser = 0;
      for (int x = 0; x < 6; x++) begin
         for (int y = 0; y < 6; y++) begin
            for (int h = 0; h < 2; h++) begin
               int s = (h == 0) ? x : y;
               int ln = s % 3 + 1;
               logic [1:0] top;
               top = (ln == 1) ? ((ser % 2 == 1) ? 2'b01 : 2'b00) : ((ln == 2) ? 2'b10 : 2'b11);
               strm[idx] = {top, 1'(s / 3), 13'(ser)};
               idx++;
               for (int k = 1; k < ln; k++) begin
                  strm[idx] = 16'(ser * 16'h3b1 + k * 16'h51d7);
                  idx++;
               end
               ser++;
            end
         end
      end
      nbody = idx;
      for (int i = idx; i < 256; i++) strm[i] = 16'h1fff;
   endtask

   task automatic run_pass(input int mode);
      int cyc = 0;
      rst_n = 1'b0; fill_valid = 1'b0; a_ready = 1'b0; b_ready = 1'b1;
      repeat (3) @(negedge clk);
      #2;
      chk(a_issue == 1'b0, "R1", "a_issue in reset", 64'(a_issue), 0);
      chk(b_issue == 1'b0, "R1", "b_issue in reset", 64'(b_issue), 0);
      chk(fill_ready == 1'b1, "R1", "fill_ready in reset", 64'(fill_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) mq[i] = '0;
      mcnt = 0; sp = 0; done_n = 0;
      while (done_n < nbody && cyc < 3000) begin
         int la, lb, cons, rem;
         bit ea, eb, memb, efr, take;
         logic [47:0] ea_syl;
         logic [31:0] eb_syl;
         string atag, btag;
         @(negedge clk);
         unique case (mode)
            0: begin a_ready = 1; b_ready = 1; fill_valid = 1; end
            1: begin a_ready = (cyc % 3 != 2); b_ready = (cyc % 2 == 0); fill_valid = 1; end
            2: begin a_ready = 1; b_ready = 1'($urandom % 2); fill_valid = ($urandom % 4 != 0); end
            default: begin a_ready = ($urandom % 4 != 0); b_ready = 1; fill_valid = ($urandom % 3 != 0); end
         endcase
         if (cyc == 0) begin a_ready = 1; b_ready = 1; fill_valid = 0; end
         for (int j = 0; j < 4; j++) fill_data[j*16 +: 16] = strm[sp + j];
         #2;
         la = lenof(mq[0]);
         ea = a_ready && (mcnt >= la);
         lb = lenof(mq[la]);
         memb = mq[la][13];
         eb = ea && b_ready && (lb == 1 || (lb == 2 && la != 3)) && !memb && (mcnt >= la + lb);
         cons = ea ? la + (eb ? lb : 0) : 0;
         rem = mcnt - cons;
         efr = (rem <= 2);
         take = fill_valid && efr;
         ea_syl = '0;
         for (int k = 0; k < 3; k++) if (ea && k < la) ea_syl[k*16 +: 16] = mq[k];
         eb_syl = '0;
         if (eb) begin
            eb_syl[15:0] = mq[la];
            if (lb == 2) eb_syl[31:16] = mq[la + 1];
         end
         if (mcnt == 0) atag = "R1";
         else if (!a_ready) atag = "R5";
         else if (mcnt < la) atag = "R4";
         else if (!b_ready) atag = "R12";
         else atag = "R3";
         if (!ea) btag = "R6";
         else if (la == 3 && lb == 2) btag = "R7";
         else if (lb == 3) btag = "R8";
         else if (memb) btag = "R9";
         else btag = "R6";
         chk(a_issue == ea, atag, "a_issue", 64'(a_issue), 64'(ea));
         chk(a_len == 2'(ea ? la : 0), "R2", "a_len", 64'(a_len), 64'(ea ? la : 0));
         chk(a_syl == ea_syl, "R10", "a_syl", 64'(a_syl), 64'(ea_syl));
         chk(b_issue == eb, btag, "b_issue", 64'(b_issue), 64'(eb));
         chk(b_len == 2'(eb ? lb : 0), "R2", "b_len", 64'(b_len), 64'(eb ? lb : 0));
         chk(b_syl == eb_syl, "R10", "b_syl", 64'(b_syl), 64'(eb_syl));
         chk(fill_ready == efr, "R11", "fill_ready", 64'(fill_ready), 64'(efr));
         // model update: shift then append (R10, R11)
         for (int i = 0; i < 6; i++) mq[i] = (i < rem) ? mq[i + cons] : 16'h0;
         if (take) begin
            for (int j = 0; j < 4; j++) mq[rem + j] = strm[sp + j];
            sp += 4;
            mcnt = rem + 4;
         end else begin
            mcnt = rem;
         end
         done_n += cons;
         cyc++;
      end
      chk(done_n >= nbody, "R10", "stream drained", 64'(done_n), 64'(nbody));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      build_stream();
      for (int m = 0; m < 4; m++) run_pass(m);
      summary();
      $finish;
   end
endmodule